// File: doc/BRIEF.md
# Register access strobe decoder

This combinational block sits between a CPU request and a fixed map of registers and external blocks. It takes a request valid bit, an address and a write flag. Within the same cycle it produces a flat vector of per-register access strobes, one strobe per external address window, one strobe per declared field, and a single flag that tells the bus front end the request must be forwarded outside the register file. Registers may be wider than the bus access width. Such a register is split into subwords, each with its own address and its own strobe bit. Register arrays with up to two dimensions are described by a base address, the two dimension sizes and an inner stride. The outer stride is derived from the inner stride and the inner dimension size.

Every dimension of the map is a parameter: the base, subword count, array shape, stride, external attribute and access capability of each register, the base and size of each block, and the register, element and bit span of each field. Elaboration checks reject a register that is neither readable nor writable, an address that does not fit the address width, a stride smaller than one element, a field outside its register, and a strobe count that disagrees with the map. The default map is listed in the requirements below.

Top module: `acc_strobe_dec`

## Requirements
- R1: With `req_vld` high, a single-word register strobes only when `req_addr` equals its byte address exactly. In the default map these are flat bit 0 at 0x000, bit 13 at 0x050 and bit 14 at 0x054.
- R2: A register of N subwords owns N strobe bits. Subword i answers at base + i*(ACC_W/8). Default: 64-bit register at 0x010 uses bit 1 (0x010) and bit 2 (0x014). Element 0 of the 2-element 64-bit array at 0x040 uses bit 9 (0x040) and bit 10 (0x044).
- R3: Array element (o,i) sits at base + o*stride*DIN + i*stride. Its strobe bits start at (o*DIN+i)*subwords. Default: the 2x3 array at 0x020 with stride 4 maps 0x020,0x024,0x028,0x02C,0x030,0x034 to bits 3..8. Element 1 of the array at 0x040 (stride 8) maps 0x048 to bit 11 and 0x04C to bit 12.
- R4: A field strobe is the OR of the strobe bits of the subwords from lsb/ACC_W to msb/ACC_W. Default: fld_strb[0] = bit 1; fld_strb[1] = bit 1 OR bit 2; fld_strb[2] = bit 12.
- R5: A block strobe asserts for every valid address from base to base+size-1 inclusive, with no further decode inside. Default: blk_strb[0] covers 0x100..0x13F and blk_strb[1] covers 0x200..0x2FF.
- R6: `is_ext` follows the strobe of a readable and writable external register and of every external block. This covers 0x054 and both blocks.
- R7: For a read-only external register (0x040..0x04C), `is_ext` is raised only on reads (`req_wr`=0). For a write-only one (0x050), it is raised only on writes. The register strobes themselves assert for both directions.
- R8: With `req_vld` low, or with an address that matches no entry (including addresses that are not word aligned), every strobe and `is_ext` are zero.
- R9: For any request, at most one bit across `reg_strb` and `blk_strb` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vld | input | 1 | Request valid |
| req_addr | input | ADDR_W | Byte address of the request, relative to the map base |
| req_wr | input | 1 | 1 for write, 0 for read |
| reg_strb | output | NUM_STRB | Flat register subword strobes |
| blk_strb | output | NUM_BLK | External block window strobes |
| fld_strb | output | NUM_FLD | Field strobes |
| is_ext | output | 1 | Request targets external storage |

## Verification
The hardest case to reach is the direction-qualified external flag. It differs from the strobe only for an external register with one-sided access. It also has to be seen at every subword of a wide, arrayed read-only register. The stimulus therefore issues both a read and a write to every address in the space. Each such pair hits every subword and array element, and every misaligned byte beside them. The pair is then checked against a reference built from the address table written in the requirements.

// File: rtl/acc_strobe_dec_pkg.sv
package acc_strobe_dec_pkg;
   // access capability codes: bit 0 = readable, bit 1 = writable
   localparam int unsigned CAP_NONE = 0;
   localparam int unsigned CAP_RD   = 1;
   localparam int unsigned CAP_WR   = 2;
   localparam int unsigned CAP_RDWR = 3;

   function automatic bit cap_legal(input int unsigned cap);
      return (cap == CAP_RD) || (cap == CAP_WR) || (cap == CAP_RDWR);
   endfunction

   function automatic bit pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/acc_reg_decode.sv
module acc_reg_decode
   import acc_strobe_dec_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned BASE   = 0,
   parameter int unsigned SUBW   = 1,
   parameter int unsigned DOUT   = 1,
   parameter int unsigned DIN    = 1,
   parameter int unsigned STRIDE = 4,
   parameter bit          IS_EXT = 1'b0,
   parameter int unsigned CAP    = CAP_RDWR,
   localparam int unsigned SUB_BYTES = ACC_W / 8,
   localparam int unsigned NBITS     = DOUT * DIN * SUBW
) (
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   output logic [NBITS-1:0]  strb,
   output logic              ext_hit
);
   localparam bit CAN_RD = (CAP & CAP_RD) != 0;
   localparam bit CAN_WR = (CAP & CAP_WR) != 0;

   if (!cap_legal(CAP)) begin : g_bad_cap
      $error("register at %0h is neither readable nor writable", BASE);
   end
   if (SUBW == 0 || DOUT == 0 || DIN == 0) begin : g_bad_shape
      $error("register at %0h has an empty shape", BASE);
   end
   if ((DOUT * DIN > 1) && (STRIDE < SUBW * SUB_BYTES)) begin : g_bad_stride
      $error("register at %0h: stride smaller than one element", BASE);
   end

   for (genvar o = 0; o < DOUT; o++) begin : g_out
      for (genvar i = 0; i < DIN; i++) begin : g_in
         for (genvar s = 0; s < SUBW; s++) begin : g_sub
            localparam int unsigned ADDR = BASE + o * STRIDE * DIN + i * STRIDE + s * SUB_BYTES;
            localparam int unsigned BIT  = (o * DIN + i) * SUBW + s;
            if (ADDR >= (1 << ADDR_W)) begin : g_bad_addr
               $error("subword address %0h beyond address width", ADDR);
            end
            assign strb[BIT] = req_vld && (req_addr == ADDR_W'(ADDR));
         end
      end
   end

   logic any_hit;
   assign any_hit = |strb;

   if (IS_EXT) begin : g_ext
      assign ext_hit = any_hit && (req_wr ? CAN_WR : CAN_RD);
   end else begin : g_int
      assign ext_hit = 1'b0;
   end
endmodule

// File: rtl/acc_blk_decode.sv
module acc_blk_decode #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned BASE   = 'h100,
   parameter int unsigned SIZE   = 'h40
) (
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit
);
   localparam int unsigned LAST = BASE + SIZE - 1;

   if (SIZE == 0) begin : g_bad_size
      $error("block at %0h has zero size", BASE);
   end
   if (BASE + SIZE > (1 << ADDR_W)) begin : g_bad_range
      $error("block at %0h extends beyond address width", BASE);
   end

   // one extra bit so the upper bound cannot wrap
   logic [ADDR_W:0] addr_x;
   assign addr_x = {1'b0, req_addr};
   assign hit = req_vld
             && (addr_x >= (ADDR_W + 1)'(BASE))
             && (addr_x <= (ADDR_W + 1)'(LAST));
endmodule

// File: rtl/acc_strobe_dec.sv
module acc_strobe_dec
   import acc_strobe_dec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned ACC_W    = 32,
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned NUM_BLK  = 2,
   parameter int unsigned NUM_FLD  = 3,
   parameter int unsigned NUM_STRB = 15,
   parameter int unsigned REG_BASE   [NUM_REGS] = '{'h000, 'h010, 'h020, 'h040, 'h050, 'h054},
   parameter int unsigned REG_SUBW   [NUM_REGS] = '{1, 2, 1, 2, 1, 1},
   parameter int unsigned REG_DOUT   [NUM_REGS] = '{1, 1, 2, 1, 1, 1},
   parameter int unsigned REG_DIN    [NUM_REGS] = '{1, 1, 3, 2, 1, 1},
   parameter int unsigned REG_STRIDE [NUM_REGS] = '{4, 8, 4, 8, 4, 4},
   parameter bit          REG_EXT    [NUM_REGS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
   parameter int unsigned REG_CAP    [NUM_REGS] = '{3, 3, 3, 1, 2, 3},
   parameter int unsigned BLK_BASE   [NUM_BLK]  = '{'h100, 'h200},
   parameter int unsigned BLK_SIZE   [NUM_BLK]  = '{'h40, 'h100},
   parameter int unsigned FLD_REG    [NUM_FLD]  = '{1, 1, 3},
   parameter int unsigned FLD_ELEM   [NUM_FLD]  = '{0, 0, 1},
   parameter int unsigned FLD_LSB    [NUM_FLD]  = '{0, 16, 40},
   parameter int unsigned FLD_MSB    [NUM_FLD]  = '{31, 47, 63}
) (
   input  logic                req_vld,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_wr,
   output logic [NUM_STRB-1:0] reg_strb,
   output logic [NUM_BLK-1:0]  blk_strb,
   output logic [NUM_FLD-1:0]  fld_strb,
   output logic                is_ext
);
   // first flat strobe bit of register k
   function automatic int unsigned flat_base(input int unsigned k);
      int unsigned acc;
      acc = 0;
      for (int unsigned j = 0; j < NUM_REGS; j++) begin
         if (j < k) acc += REG_SUBW[j] * REG_DOUT[j] * REG_DIN[j];
      end
      return acc;
   endfunction

   localparam int unsigned TOTAL_STRB = flat_base(NUM_REGS);

   // elaboration checks on the global shape
   if (ACC_W < 8 || !pow2(ACC_W)) begin : g_bad_accw
      $error("access width %0d must be a power of two of at least 8", ACC_W);
   end
   if (ADDR_W == 0 || ADDR_W > 30) begin : g_bad_addrw
      $error("address width %0d out of range", ADDR_W);
   end
   if (TOTAL_STRB != NUM_STRB) begin : g_bad_count
      $error("NUM_STRB %0d disagrees with map total %0d", NUM_STRB, TOTAL_STRB);
   end

   // register decoders
   logic [NUM_REGS-1:0] reg_ext;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam int unsigned LO = flat_base(k);
      localparam int unsigned W  = REG_SUBW[k] * REG_DOUT[k] * REG_DIN[k];
      acc_reg_decode #(
         .ADDR_W (ADDR_W),
         .ACC_W  (ACC_W),
         .BASE   (REG_BASE[k]),
         .SUBW   (REG_SUBW[k]),
         .DOUT   (REG_DOUT[k]),
         .DIN    (REG_DIN[k]),
         .STRIDE (REG_STRIDE[k]),
         .IS_EXT (REG_EXT[k]),
         .CAP    (REG_CAP[k])
      ) reg_dec_i (
         .req_vld  (req_vld),
         .req_addr (req_addr),
         .req_wr   (req_wr),
         .strb     (reg_strb[LO +: W]),
         .ext_hit  (reg_ext[k])
      );
   end

   // external block windows
   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      acc_blk_decode #(
         .ADDR_W (ADDR_W),
         .BASE   (BLK_BASE[b]),
         .SIZE   (BLK_SIZE[b])
      ) blk_dec_i (
         .req_vld  (req_vld),
         .req_addr (req_addr),
         .hit      (blk_strb[b])
      );
   end

   // field strobes: OR over the subword slice the field spans
   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      localparam int unsigned R  = FLD_REG[f];
      localparam int unsigned EB = flat_base(R) + FLD_ELEM[f] * REG_SUBW[R];
      localparam int unsigned LO = EB + FLD_LSB[f] / ACC_W;
      localparam int unsigned HI = EB + FLD_MSB[f] / ACC_W;
      if (R >= NUM_REGS) begin : g_bad_reg
         $error("field %0d refers to missing register %0d", f, R);
      end
      if (FLD_ELEM[f] >= REG_DOUT[R] * REG_DIN[R]) begin : g_bad_elem
         $error("field %0d element index out of range", f);
      end
      if (FLD_MSB[f] < FLD_LSB[f] || FLD_MSB[f] >= REG_SUBW[R] * ACC_W) begin : g_bad_bits
         $error("field %0d bit span invalid", f);
      end
      if (HI == LO) begin : g_one
         assign fld_strb[f] = reg_strb[LO];
      end else begin : g_many
         assign fld_strb[f] = |reg_strb[HI:LO];
      end
   end

   assign is_ext = (|reg_ext) || (|blk_strb);
endmodule

// File: rtl/acc_strobe_dec_chk.sv
module acc_strobe_dec_chk #(
   parameter int unsigned NUM_STRB = 15,
   parameter int unsigned NUM_BLK  = 2,
   parameter int unsigned NUM_FLD  = 3
) (
   input logic                req_vld,
   input logic [NUM_STRB-1:0] reg_strb,
   input logic [NUM_BLK-1:0]  blk_strb,
   input logic [NUM_FLD-1:0]  fld_strb,
   input logic                is_ext
);
   always_comb begin
      // R8: idle request drives nothing
      assert_idle_quiet_R8: assert (req_vld || ((reg_strb == '0) && (blk_strb == '0)
                                                && (fld_strb == '0) && !is_ext));
      // R9: decoded targets are mutually exclusive
      assert_single_target_R9: assert ($onehot0({reg_strb, blk_strb}));
      // R6: external flag needs a decoded target
      assert_ext_has_target_R6: assert (!is_ext || (|reg_strb) || (|blk_strb));
      // R4: a field strobe needs a register strobe
      assert_fld_has_reg_R4: assert (!(|fld_strb) || (|reg_strb));
   end
endmodule

bind acc_strobe_dec acc_strobe_dec_chk #(
   .NUM_STRB (NUM_STRB),
   .NUM_BLK  (NUM_BLK),
   .NUM_FLD  (NUM_FLD)
) chk_i (
   .req_vld  (req_vld),
   .reg_strb (reg_strb),
   .blk_strb (blk_strb),
   .fld_strb (fld_strb),
   .is_ext   (is_ext)
);

// File: tb/acc_strobe_dec_tb_top.sv
module acc_strobe_dec_tb_top;
   localparam int AW = 12;
   localparam int NS = 15;

   typedef struct packed {
      logic          vld;
      logic          wr;
      logic [AW-1:0] addr;
      logic [NS-1:0] strb;
      logic [1:0]    blk;
      logic [2:0]    fld;
      logic          ext;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          req_vld = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_wr = 1'b0;
   logic [NS-1:0] reg_strb;
   logic [1:0]    blk_strb;
   logic [2:0]    fld_strb;
   logic          is_ext;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   item_t sb_q[$];

   always #2 clk = ~clk; // 250 MHz

   acc_strobe_dec dut_i (
      .req_vld (req_vld), .req_addr (req_addr), .req_wr (req_wr),
      .reg_strb (reg_strb), .blk_strb (blk_strb), .fld_strb (fld_strb),
      .is_ext (is_ext)
   );

   // reference model from the requirement tables
   function automatic item_t model(input logic v, input logic [AW-1:0] a, input logic w);
      item_t e;
      e = '0;
      e.vld = v; e.wr = w; e.addr = a;
      if (v) begin
         case (a)
            12'h000: e.strb[0]  = 1'b1;
            12'h010: e.strb[1]  = 1'b1;
            12'h014: e.strb[2]  = 1'b1;
            12'h020: e.strb[3]  = 1'b1;
            12'h024: e.strb[4]  = 1'b1;
            12'h028: e.strb[5]  = 1'b1;
            12'h02C: e.strb[6]  = 1'b1;
            12'h030: e.strb[7]  = 1'b1;
            12'h034: e.strb[8]  = 1'b1;
            12'h040: e.strb[9]  = 1'b1;
            12'h044: e.strb[10] = 1'b1;
            12'h048: e.strb[11] = 1'b1;
            12'h04C: e.strb[12] = 1'b1;
            12'h050: e.strb[13] = 1'b1;
            12'h054: e.strb[14] = 1'b1;
            default: ;
         endcase
         e.blk[0] = (a >= 12'h100) && (a <= 12'h13F);
         e.blk[1] = (a >= 12'h200) && (a <= 12'h2FF);
         e.fld[0] = e.strb[1];
         e.fld[1] = e.strb[1] | e.strb[2];
         e.fld[2] = e.strb[12];
         e.ext = (|e.strb[12:9] && !w) || (e.strb[13] && w) || e.strb[14] || (|e.blk);
      end
      return e;
   endfunction

   function automatic string strb_tag(input item_t e);
      if (!e.vld) return "R8";
      case (e.addr)
         12'h000, 12'h050, 12'h054: return "R1";
         12'h010, 12'h014, 12'h040, 12'h044: return "R2";
         12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048, 12'h04C: return "R3";
         default: return "R8";
      endcase
   endfunction

   function automatic string ext_tag(input item_t e);
      if (!e.vld) return "R8";
      if (e.addr >= 12'h040 && e.addr <= 12'h050) return "R7";
      if (e.addr == 12'h054 || (|e.blk)) return "R6";
      return "R8";
   endfunction

   task automatic check(input string tag, input string what, input item_t e,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s vld=%0b wr=%0b addr=%03h actual=%0h expected=%0h",
                  tag, what, e.vld, e.wr, e.addr, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [AW-1:0] a, input logic w);
      @(posedge clk);
      req_vld = v; req_addr = a; req_wr = w;
      sb_q.push_back(model(v, a, w));
   endtask

   // monitor: compare between clock edges
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            check(strb_tag(e), "reg_strb", e, 32'(reg_strb), 32'(e.strb));
            check((|e.blk) ? "R5" : "R8", "blk_strb", e, 32'(blk_strb), 32'(e.blk));
            check("R4", "fld_strb", e, 32'(fld_strb), 32'(e.fld));
            check(ext_tag(e), "is_ext", e, 32'(is_ext), 32'(e.ext));
            check("R9", "target_count", e, 32'($countones({reg_strb, blk_strb})),
                  32'($countones({e.strb, e.blk})));
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // idle state after reset (R8)
      drive(1'b0, 12'h000, 1'b0);
      // full sweep, read then write at every address (R1..R9)
      for (int a = 0; a < (1 << AW); a++) begin
         drive(1'b1, AW'(a), 1'b0);
         drive(1'b1, AW'(a), 1'b1);
      end
      // valid low over mapped and unmapped addresses (R8)
      for (int a = 0; a < 256; a++) begin
         drive(1'b0, AW'(a * 4), a[0]);
      end
      drive(1'b0, 12'h054, 1'b1);
      wait (sb_q.size() == 0);
      @(negedge clk);
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule